// File: doc/BRIEF.md
# Multi-Lane Pixel Stream Merger

This block gathers pixel samples from a readout chip that drives many parallel lanes (24 by default). Every lane feeds its own small elastic FIFO in the slow readout clock domain. A single frame controller waits until every active lane has a frame start at the head of its FIFO. It then sends one header word, pops all active lanes together, and packs one 16-bit pixel per lane into a wide word. Frames continue until an end-of-frame flag is seen. The wide words cross into the fast streaming clock domain through a gray-pointer dual-clock FIFO. They leave on a valid/ready stream that carries a last flag and an error flag.

A lane takes part only when both its enable bit and its lock bit are set. When a lane is left out and the enumeration test mode is on, the lane's slot in every data word carries a code built from its own index. This lets downstream software confirm where each lane lands in the word. Two saturating counters record lost or stalled traffic. One counts cycles in which an incoming lane sample hit a full lane FIFO. The other counts cycles in which the controller had a word ready while the wide FIFO was full.

The depths are parameters and must be powers of two. The production setting is 512 entries per lane and 8192 wide entries, with 3072 pixels per lane per frame. The defaults are kept small so that the design elaborates quickly, and frame length is set only by the end-of-frame flags.

Top module: `pix_lane_merger`

## Requirements
- R1: A lane write is an entry with bit 18 = frame start, bit 17 = frame end, bit 16 = error and bits 15:0 = pixel. Lane i is active when lane_en[i] and lane_lock[i] are both 1, so a fully locked and enabled chip has a mask of 24'hFFFFFF. Entries of an active lane are delivered in the order written.
- R2: Each frame opens with one header word. Bits 31:0 hold the frame sequence number, which is 0 for the first frame after reset and rises by 1 per frame. Bits 55:32 hold the active mask latched at frame start. Bits 383:376 hold 8'hA5 and all other bits are 0. The header has out_last = 0 and out_err = 0.
- R3: In each data word, lane i's pixel occupies bits 16*i+15 : 16*i. All active lanes are popped together, one entry each, per data word.
- R4: The data word built from entries where any active lane carries the frame-end flag has out_last = 1, and it closes the frame.
- R5: out_err of a data word is the OR of the error flags of the active lanes' entries in that word.
- R6: While no frame is open, an entry at the head of an active lane FIFO without the frame-start flag is discarded and produces no output.
- R7: The slot of an inactive lane is 16'h0000 when enum_mode is 0, and 16'hE000 | i when enum_mode is 1. Writes to an inactive lane are discarded.
- R8: A word offered on the output stays valid and unchanged until it is accepted. When the wide FIFO is full the controller waits, so no word is lost or repeated.
- R9: merge_ovf_cnt rises by 1 in each write-clock cycle in which the controller holds a pending word and the wide FIFO is full. A word is pending when it is a header, or a data word with every active lane non-empty. The counter does not change in any other cycle.
- R10: lane_ovf_cnt rises by 1 in each write-clock cycle in which at least one active lane write meets a full lane FIFO. Such an entry is dropped.
- R11: Both counters are CNT_W bits wide (32 by default) and stop at their maximum value. cnt_clr clears both on the next write-clock edge and takes priority over an increment.
- R12: After reset out_valid is 0 and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Slow readout clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| lane_wvalid | input | LANES | Per-lane write strobe |
| lane_wdata | input | LANES*19 | Per-lane entries, lane i at bits 19*i+18 : 19*i |
| lane_en | input | LANES | Lane enable mask |
| lane_lock | input | LANES | Lane lock status mask |
| enum_mode | input | 1 | Lane-index pattern for inactive lanes |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| lane_ovf_cnt | output | CNT_W | Lane FIFO overflow cycles |
| merge_ovf_cnt | output | CNT_W | Wide FIFO full-stall cycles |
| rd_clk | input | 1 | Fast streaming clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word accepted |
| out_data | output | LANES*16 | Header or packed pixel word |
| out_last | output | 1 | Final word of a frame |
| out_err | output | 1 | Error flag of a data word |

## Verification
The counters are registered, so each one reflects a write-domain event at the next wr_clk edge. The bench therefore reads them at falling edges, a whole number of cycles after the stimulus, and compares differences over fixed windows of stalled cycles. Output words cross a clock boundary, and their arrival cycle depends on synchronizer timing rather than a fixed count. For that reason the reference model is an ordered queue of expected words: at every read-clock falling edge where valid and ready are both high, the word that is about to be accepted is compared with the head of the queue. Cases with a predictable loss, such as dropping entries on full lane FIFOs, are checked by word count and by the drop count (entries beyond the combined wide and lane storage).

// File: rtl/plm_pkg.sv
`timescale 1ns/1ps
package plm_pkg;
    localparam int PIX_W   = 16;
    localparam int FLAG_W  = 3;
    localparam int ENTRY_W = PIX_W + FLAG_W;
    localparam int SEQ_W   = 32;
    localparam logic [7:0]       HDR_MARK  = 8'hA5;
    localparam logic [PIX_W-1:0] ENUM_BASE = 16'hE000;

    typedef struct packed {
        logic             sof;
        logic             eof;
        logic             err;
        logic [PIX_W-1:0] pix;
    } lane_entry_t;

    typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} plm_state_e;

    function automatic logic [PIX_W-1:0] enum_pix(input int unsigned lane);
        return ENUM_BASE | PIX_W'(lane);
    endfunction
endpackage

// File: rtl/plm_lane_fifo.sv
`timescale 1ns/1ps
module plm_lane_fifo #(
    parameter int WIDTH = 19,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             drop
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             full, do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wdata;
                wp      <= wp + AW'(1);
            end
            if (do_pop) rp <= rp + AW'(1);
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/plm_xclk_fifo.sv
`timescale 1ns/1ps
module plm_xclk_fifo #(
    parameter int WIDTH = 386,
    parameter int DEPTH = 16
) (
    input  logic             wclk,
    input  logic             wrst,
    input  logic             wen,
    input  logic [WIDTH-1:0] wdata,
    output logic             wfull,
    input  logic             rclk,
    input  logic             rrst,
    output logic             rvalid,
    input  logic             rready,
    output logic [WIDTH-1:0] rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_FLIP = {2'b11, {(AW-1){1'b0}}};

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0] wbin, wgray, rbin, rgray;
    logic [AW:0] rg_s1, rg_s2, wg_s1, wg_s2;
    logic [AW:0] wnext, rnext;

    assign wnext  = wbin + (AW+1)'(1);
    assign rnext  = rbin + (AW+1)'(1);
    assign wfull  = (wgray == (rg_s2 ^ FULL_FLIP));
    assign rvalid = (rgray != wg_s2);
    assign rdata  = mem[rbin[AW-1:0]];

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            rg_s1 <= '0;
            rg_s2 <= '0;
        end else begin
            rg_s1 <= rgray;
            rg_s2 <= rg_s1;
            if (wen && !wfull) begin
                mem[wbin[AW-1:0]] <= wdata;
                wbin  <= wnext;
                wgray <= wnext ^ (wnext >> 1);
            end
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wg_s1 <= '0;
            wg_s2 <= '0;
        end else begin
            wg_s1 <= wgray;
            wg_s2 <= wg_s1;
            if (rvalid && rready) begin
                rbin  <= rnext;
                rgray <= rnext ^ (rnext >> 1);
            end
        end
    end
endmodule

// File: rtl/plm_sat_cnt.sv
`timescale 1ns/1ps
module plm_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)             cnt <= '0;
        else if (inc && cnt != '1) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/plm_frame_ctrl.sv
`timescale 1ns/1ps
module plm_frame_ctrl
    import plm_pkg::*;
#(
    parameter int LANES  = 24,
    parameter int WORD_W = LANES * PIX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         active,
    input  logic [LANES-1:0]         lane_empty,
    input  logic [LANES*ENTRY_W-1:0] lane_head,
    input  logic                     enum_mode,
    input  logic                     m_full,
    output logic [LANES-1:0]         lane_pop,
    output logic                     m_wr,
    output logic [WORD_W+1:0]        m_wdata,
    output logic                     stall
);
    plm_state_e       state;
    logic [LANES-1:0] mask_q;
    logic [SEQ_W-1:0] seq_q;
    logic [LANES-1:0] head_sof, head_eof, head_err;
    logic [WORD_W-1:0] pix_word, hdr_word;
    logic [LANES-1:0] stray;
    logic             start_ok, data_rdy, frame_end;

    always_comb begin
        lane_entry_t e;
        pix_word = '0;
        for (int i = 0; i < LANES; i++) begin
            e = lane_entry_t'(lane_head[i*ENTRY_W +: ENTRY_W]);
            head_sof[i] = e.sof;
            head_eof[i] = e.eof;
            head_err[i] = e.err;
            if (mask_q[i])      pix_word[i*PIX_W +: PIX_W] = e.pix;
            else if (enum_mode) pix_word[i*PIX_W +: PIX_W] = enum_pix(i);
        end
    end

    always_comb begin
        hdr_word = '0;
        hdr_word[SEQ_W-1:0]        = seq_q;
        hdr_word[SEQ_W +: LANES]   = mask_q;
        hdr_word[WORD_W-1 -: 8]    = HDR_MARK;
    end

    assign stray     = active & ~lane_empty & ~head_sof;
    assign start_ok  = (active != '0) && ((active & ~lane_empty & head_sof) == active);
    assign data_rdy  = ((mask_q & ~lane_empty) == mask_q);
    assign frame_end = |(mask_q & head_eof);

    always_comb begin
        lane_pop = '0;
        m_wr     = 1'b0;
        stall    = 1'b0;
        m_wdata  = {2'b00, hdr_word};
        case (state)
            ST_IDLE: lane_pop = stray;
            ST_HDR: begin
                if (m_full) stall = 1'b1;
                else        m_wr  = 1'b1;
            end
            ST_DATA: begin
                m_wdata = {frame_end, |(mask_q & head_err), pix_word};
                if (data_rdy) begin
                    if (m_full) stall = 1'b1;
                    else begin
                        m_wr     = 1'b1;
                        lane_pop = mask_q;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mask_q <= '0;
            seq_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_ok && stray == '0) begin
                    mask_q <= active;
                    state  <= ST_HDR;
                end
                ST_HDR: if (!m_full) begin
                    seq_q <= seq_q + SEQ_W'(1);
                    state <= ST_DATA;
                end
                ST_DATA: if (data_rdy && !m_full && frame_end) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pix_lane_merger.sv
`timescale 1ns/1ps
module pix_lane_merger
    import plm_pkg::*;
#(
    parameter int LANES       = 24,
    parameter int LANE_DEPTH  = 16,
    parameter int MERGE_DEPTH = 16,
    parameter int CNT_W       = 32
) (
    input  logic                     wr_clk,
    input  logic                     wr_rst,
    input  logic [LANES-1:0]         lane_wvalid,
    input  logic [LANES*ENTRY_W-1:0] lane_wdata,
    input  logic [LANES-1:0]         lane_en,
    input  logic [LANES-1:0]         lane_lock,
    input  logic                     enum_mode,
    input  logic                     cnt_clr,
    output logic [CNT_W-1:0]         lane_ovf_cnt,
    output logic [CNT_W-1:0]         merge_ovf_cnt,
    input  logic                     rd_clk,
    input  logic                     rd_rst,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES*PIX_W-1:0]   out_data,
    output logic                     out_last,
    output logic                     out_err
);
    localparam int WORD_W = LANES * PIX_W;
    localparam int MW     = WORD_W + 2;

    logic [LANES-1:0]         active, lane_empty, lane_pop, lane_drop;
    logic [LANES*ENTRY_W-1:0] lane_head;
    logic                     m_wr, m_full, merge_stall;
    logic [MW-1:0]            m_wdata, m_rdata;

    assign active = lane_en & lane_lock;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        plm_lane_fifo #(.WIDTH(ENTRY_W), .DEPTH(LANE_DEPTH)) u_fifo (
            .clk   (wr_clk),
            .rst   (wr_rst),
            .flush (!active[g]),
            .push  (lane_wvalid[g] && active[g]),
            .wdata (lane_wdata[g*ENTRY_W +: ENTRY_W]),
            .pop   (lane_pop[g]),
            .head  (lane_head[g*ENTRY_W +: ENTRY_W]),
            .empty (lane_empty[g]),
            .drop  (lane_drop[g])
        );
    end

    plm_frame_ctrl #(.LANES(LANES), .WORD_W(WORD_W)) u_ctrl (
        .clk        (wr_clk),
        .rst        (wr_rst),
        .active     (active),
        .lane_empty (lane_empty),
        .lane_head  (lane_head),
        .enum_mode  (enum_mode),
        .m_full     (m_full),
        .lane_pop   (lane_pop),
        .m_wr       (m_wr),
        .m_wdata    (m_wdata),
        .stall      (merge_stall)
    );

    plm_xclk_fifo #(.WIDTH(MW), .DEPTH(MERGE_DEPTH)) u_xfifo (
        .wclk   (wr_clk),
        .wrst   (wr_rst),
        .wen    (m_wr),
        .wdata  (m_wdata),
        .wfull  (m_full),
        .rclk   (rd_clk),
        .rrst   (rd_rst),
        .rvalid (out_valid),
        .rready (out_ready),
        .rdata  (m_rdata)
    );

    assign out_last = m_rdata[WORD_W+1];
    assign out_err  = m_rdata[WORD_W];
    assign out_data = m_rdata[WORD_W-1:0];

    plm_sat_cnt #(.W(CNT_W)) u_lane_cnt (
        .clk (wr_clk), .rst (wr_rst), .clr (cnt_clr),
        .inc (|lane_drop), .cnt (lane_ovf_cnt)
    );

    plm_sat_cnt #(.W(CNT_W)) u_merge_cnt (
        .clk (wr_clk), .rst (wr_rst), .clr (cnt_clr),
        .inc (merge_stall), .cnt (merge_ovf_cnt)
    );
endmodule

// File: rtl/plm_checker.sv
`timescale 1ns/1ps
module plm_checker #(
    parameter int CNT_W  = 32,
    parameter int LANES  = 24,
    parameter int WORD_W = 384
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              cnt_clr,
    input logic [CNT_W-1:0]  lane_ovf_cnt,
    input logic [CNT_W-1:0]  merge_ovf_cnt,
    input logic              m_wr,
    input logic              m_full,
    input logic              merge_stall,
    input logic [LANES-1:0]  lane_drop,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last
);
    // R8
    no_write_when_full_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        m_wr |-> !m_full);

    // R8
    hold_under_backpressure_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    merge_cnt_idle_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!cnt_clr && !merge_stall) |=> $stable(merge_ovf_cnt));

    // R10
    lane_cnt_idle_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!cnt_clr && lane_drop == '0) |=> $stable(lane_ovf_cnt));

    // R11
    counter_clear_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        cnt_clr |=> (merge_ovf_cnt == '0 && lane_ovf_cnt == '0));

    // R11
    merge_cnt_saturate_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (merge_ovf_cnt == '1 && !cnt_clr) |=> merge_ovf_cnt == '1);
endmodule

bind pix_lane_merger plm_checker #(.CNT_W(CNT_W), .LANES(LANES), .WORD_W(WORD_W)) u_chk (
    .wr_clk        (wr_clk),
    .wr_rst        (wr_rst),
    .rd_clk        (rd_clk),
    .rd_rst        (rd_rst),
    .cnt_clr       (cnt_clr),
    .lane_ovf_cnt  (lane_ovf_cnt),
    .merge_ovf_cnt (merge_ovf_cnt),
    .m_wr          (m_wr),
    .m_full        (m_full),
    .merge_stall   (merge_stall),
    .lane_drop     (lane_drop),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_last      (out_last)
);

// File: tb/pix_lane_merger_bench.sv
`timescale 1ns/1ps
module pix_lane_merger_bench;
    localparam int LANES = 24;
    localparam int EW    = 19;
    localparam int WW    = LANES * 16;
    localparam int LD    = 16;
    localparam int MD    = 16;

    logic              wr_clk = 0, rd_clk = 0;
    logic              wr_rst = 1, rd_rst = 1;
    logic [LANES-1:0]  lane_wvalid = '0;
    logic [LANES*EW-1:0] lane_wdata = '0;
    logic [LANES-1:0]  lane_en = '1, lane_lock = '1;
    logic              enum_mode = 0, cnt_clr = 0;
    logic [31:0]       lane_ovf_cnt, merge_ovf_cnt;
    logic              out_valid, out_ready = 0, out_last, out_err;
    logic [WW-1:0]     out_data;

    always #10 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    pix_lane_merger u_pix_lane_merger (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .lane_wvalid(lane_wvalid), .lane_wdata(lane_wdata),
        .lane_en(lane_en), .lane_lock(lane_lock), .enum_mode(enum_mode), .cnt_clr(cnt_clr),
        .lane_ovf_cnt(lane_ovf_cnt), .merge_ovf_cnt(merge_ovf_cnt),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_err(out_err)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [WW-1:0] exp_d [$];
    logic          exp_l [$];
    logic          exp_e [$];
    string         exp_t [$];
    int            seq_m = 0;
    int            frame_no = 0;
    int            rdy_mode = 0;
    logic [15:0]   lfsr = 16'hACE1;
    bit            sb_on = 1;
    int            rx_cnt = 0, rx_last = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] pix_of(input int fr, input int lane, input int k);
        return 16'((fr * 37 + lane * 211 + k * 5 + 3) & 16'hFFFF);
    endfunction

    // read side: drive ready, then compare the word about to be accepted
    always @(negedge rd_clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
        endcase
        #1;
        if (out_valid && out_ready) begin
            if (!sb_on) begin
                rx_cnt++;
                if (out_last) rx_last++;
            end else if (exp_d.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 unexpected word actual=%0h expected=none", out_data[63:0]);
            end else begin
                logic [WW-1:0] d; logic l, e; string t;
                d = exp_d.pop_front(); l = exp_l.pop_front();
                e = exp_e.pop_front(); t = exp_t.pop_front();
                checks++;
                if (out_data !== d || out_last !== l || out_err !== e) begin
                    fails++;
                    $display("FAIL %s word actual=%h/%b/%b expected=%h/%b/%b",
                             t, out_data, out_last, out_err, d, l, e);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge wr_clk);
        wr_rst = 1; rd_rst = 1; lane_wvalid = '0;
        repeat (4) @(negedge wr_clk);
        exp_d.delete(); exp_l.delete(); exp_e.delete(); exp_t.delete();
        seq_m = 0; sb_on = 1; rx_cnt = 0; rx_last = 0;
        wr_rst = 0; rd_rst = 0;
        repeat (2) @(negedge wr_clk);
    endtask

    // R1 R2 R3 R4 R5 R7: model of one frame, then its lane writes
    task automatic send_frame(input int len, input int err_k, input int err_lane, input string tag);
        logic [LANES-1:0] mask;
        logic [WW-1:0] w;
        logic last, e;
        mask = lane_en & lane_lock;
        w = '0; w[31:0] = 32'(seq_m); w[32 +: LANES] = mask; w[WW-1 -: 8] = 8'hA5;
        exp_d.push_back(w); exp_l.push_back(1'b0); exp_e.push_back(1'b0); exp_t.push_back("R2");
        seq_m++;
        for (int k = 0; k < len; k++) begin
            w = '0;
            for (int l = 0; l < LANES; l++)
                if (mask[l]) w[l*16 +: 16] = pix_of(frame_no, l, k);
                else if (enum_mode) w[l*16 +: 16] = 16'hE000 | 16'(l);
            last = (k == len - 1);
            e = (k == err_k) && mask[err_lane];
            exp_d.push_back(w); exp_l.push_back(last); exp_e.push_back(e);
            exp_t.push_back(last ? "R4" : (e ? "R5" : tag));
        end
        for (int k = 0; k < len; k++) begin
            @(negedge wr_clk);
            lane_wvalid = '1;
            for (int l = 0; l < LANES; l++)
                lane_wdata[l*EW +: EW] = {k == 0, k == len - 1, (k == err_k) && (l == err_lane),
                                          pix_of(frame_no, l, k)};
        end
        @(negedge wr_clk);
        lane_wvalid = '0;
        frame_no++;
    endtask

    task automatic send_stray(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge wr_clk);
            lane_wvalid = '1;
            for (int l = 0; l < LANES; l++)
                lane_wdata[l*EW +: EW] = {1'b0, 1'b1, 1'b1, 16'hDEAD};
        end
        @(negedge wr_clk);
        lane_wvalid = '0;
    endtask

    task automatic drain(input string tag);
        rdy_mode = 0;
        for (int i = 0; i < 3000 && exp_d.size() != 0; i++) @(negedge wr_clk);
        repeat (4) @(negedge wr_clk);
        check(exp_d.size() == 0, tag, 64'(exp_d.size()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0, c1;
        do_reset();
        // R12 reset state
        check(out_valid == 1'b0, "R12 out_valid", 64'(out_valid), 64'd0);
        check(lane_ovf_cnt == 0, "R12 lane_ovf_cnt", 64'(lane_ovf_cnt), 64'd0);
        check(merge_ovf_cnt == 0, "R12 merge_ovf_cnt", 64'(merge_ovf_cnt), 64'd0);

        // R1 R3 all lanes, free-flowing output
        rdy_mode = 0;
        send_frame(6, -1, 0, "R1");
        send_frame(3, -1, 0, "R3");
        drain("R1 drain");

        // R5 R8 error flags with random backpressure
        rdy_mode = 1;
        send_frame(9, 4, 7, "R8");
        send_frame(1, 0, 23, "R5");
        send_frame(5, 2, 0, "R8");
        drain("R8 drain");

        // R6 stray entries before a frame
        send_stray(3);
        send_frame(4, -1, 0, "R6");
        drain("R6 drain");

        // R7 enumeration pattern on disabled lanes
        lane_en = 24'h0F0FF0; enum_mode = 1;
        repeat (3) @(negedge wr_clk);
        send_frame(5, -1, 0, "R7");
        drain("R7 enum drain");
        // R7 zero fill on unlocked lanes
        lane_en = '1; lane_lock = 24'hFFF0FF; enum_mode = 0;
        repeat (3) @(negedge wr_clk);
        send_frame(4, 1, 9, "R7");
        drain("R7 zero drain");
        lane_lock = '1;
        repeat (3) @(negedge wr_clk);
        check(lane_ovf_cnt == 0, "R10 no drops", 64'(lane_ovf_cnt), 64'd0);

        // R8 R9 full wide FIFO, nothing lost
        do_reset();
        rdy_mode = 2;
        send_frame(20, -1, 0, "R8");
        repeat (10) @(negedge wr_clk);
        c0 = merge_ovf_cnt;
        repeat (10) @(negedge wr_clk);
        c1 = merge_ovf_cnt;
        check(c1 - c0 == 10, "R9 stall count", 64'(c1 - c0), 64'd10);
        check(lane_ovf_cnt == 0, "R10 no drop while lanes have room", 64'(lane_ovf_cnt), 64'd0);
        drain("R8 full drain");
        c0 = merge_ovf_cnt;
        repeat (8) @(negedge wr_clk);
        check(merge_ovf_cnt == c0, "R9 no pending word", 64'(merge_ovf_cnt), 64'(c0));

        // R10 R11 lane overflow and clear
        do_reset();
        rdy_mode = 2;
        sb_on = 0;
        send_frame(40, -1, 0, "R10");
        repeat (20) @(negedge wr_clk);
        check(lane_ovf_cnt == 40 - (MD - 1) - LD, "R10 drop count", 64'(lane_ovf_cnt),
              64'(40 - (MD - 1) - LD));
        cnt_clr = 1;
        @(negedge wr_clk);
        check(lane_ovf_cnt == 0, "R11 lane clear", 64'(lane_ovf_cnt), 64'd0);
        check(merge_ovf_cnt == 0, "R11 merge clear", 64'(merge_ovf_cnt), 64'd0);
        cnt_clr = 0;
        @(negedge wr_clk);
        check(merge_ovf_cnt == 1, "R11 count after clear", 64'(merge_ovf_cnt), 64'd1);
        check(lane_ovf_cnt == 0, "R11 lane stays clear", 64'(lane_ovf_cnt), 64'd0);
        rdy_mode = 0;
        repeat (100) @(negedge wr_clk);
        check(rx_cnt == MD + LD, "R10 words kept", 64'(rx_cnt), 64'(MD + LD));
        check(rx_last == 0, "R10 dropped end flag", 64'(rx_last), 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule